// File: doc/BRIEF.md
# Triggered Conditional DMA Sequencer

This block is the control engine that runs a conditional step ahead of a data transfer. Once started, it watches one line of a 64-line trigger vector. Each time that line is high while the engine is waiting, it reads a status register through a small request/response port. It then tests the returned word against a compare value and a mask. The test is either masked-equal or masked-not-equal, chosen by a condition-type input. When the test passes, the engine asks the datapath to move one chunk of the data transfer and waits for the datapath to report the chunk done. It then goes back to watching the trigger.

The chunks add up to one pass of the data transfer. The whole transfer is run a programmed number of times. An optional retry limit bounds the number of failed tests in a row. An optional cycle timeout bounds how long the engine waits for a trigger. If the timeout expires, the engine waits until any pending write-back has finished and then halts with a timeout error. If the conditional features are not switched on, a start runs a single plain transfer of the full size.

The descriptor fields arrive as inputs and must be held stable while `busy` is high. The read-request port and the chunk-request port are valid/ready: the engine raises valid and holds valid and its payload unchanged until it sees ready high at a clock edge. The datapath may hold ready low as long as it needs. The read response and the chunk-done signal are single-cycle pulses with no back-pressure. The engine accepts a response or a done pulse only while it is waiting for one.

Top module: `cond_dma_seq`

## Requirements
- R1: Conditional operation is active only when `ext_mode_en` is 1, `desc_ver` equals 1 and `trig_en` is 1. Otherwise a start issues exactly one chunk request whose length is `total_size`, issues no read request, and sets `done` after that chunk completes.
- R2: Only trigger line number `cond_sel` (a 6-bit index into `trig_vec`) can start a conditional step. Activity on all other lines has no effect.
- R3: While waiting, a high selected line starts one read request with `rd_addr` equal to `status_addr`. `rd_valid` stays high until `rd_ready` is seen high.
- R4: For `cond_type` 0, the test passes when ((`cmp_data` XOR read word) AND `cmp_mask`) is zero. For `cond_type` 1, it passes when that value is nonzero. A failed test moves no data.
- R5: Each passing test issues exactly one chunk request. `xfer_valid` and `xfer_len` hold steady until `xfer_ready` is seen high. After `xfer_done`, the engine waits for the trigger again.
- R6: Each chunk is `chunk_size` bytes. The last chunk of a pass is cut down to the bytes that remain. A `chunk_size` of 0 means the whole remainder.
- R7: A pass ends when its chunks add up to `total_size`. After `loop_cnt` passes, `done` is set and the engine goes idle. A start with `total_size` 0, or with `loop_cnt` 0 in conditional mode, sets `done` at once.
- R8: With `retry_en` set, failed tests in a row are counted, and a passing test clears the count. A failure that arrives when the count already equals `retry_limit` sets `retry_error` and stops the engine. With `retry_en` clear, failures are unlimited.
- R9: With `tmo_en` set, a counter loaded with `tmo_reload` counts down in each waiting cycle and reloads whenever a trigger is accepted. If it reaches zero with no trigger, the engine stops. It sets `timeout_error` only once `wb_busy` is low.
- R10: `done`, `retry_error` and `timeout_error` are mutually exclusive. Each stays set until `clr_status`, a new start, or reset.
- R11: After reset the engine is idle: `busy`, all status outputs, `rd_valid` and `xfer_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode_en | input | 1 | Global enable for conditional operation |
| desc_ver | input | 4 | Descriptor version; 1 selects conditional |
| trig_en | input | 1 | Descriptor trigger enable |
| cond_sel | input | 6 | Trigger line index |
| cond_type | input | 1 | 0 masked-equal, 1 masked-not-equal |
| cmp_data | input | 32 | Compare value |
| cmp_mask | input | 32 | Compare mask |
| status_addr | input | 32 | Address of the polled status register |
| chunk_size | input | 16 | Bytes per chunk |
| total_size | input | 16 | Bytes per pass |
| loop_cnt | input | 16 | Number of passes |
| retry_en | input | 1 | Enable retry limit |
| retry_limit | input | 16 | Allowed consecutive failed tests |
| tmo_en | input | 1 | Enable wait timeout |
| tmo_reload | input | 32 | Timeout length in cycles |
| start | input | 1 | Start pulse, taken when idle |
| clr_status | input | 1 | Clears status outputs |
| trig_vec | input | 64 | Trigger lines |
| wb_busy | input | 1 | Write-back pending |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read address |
| rd_rvalid | input | 1 | Read response pulse |
| rd_rdata | input | 32 | Read response word |
| xfer_valid | output | 1 | Chunk request valid |
| xfer_ready | input | 1 | Chunk request accepted |
| xfer_len | output | 16 | Chunk length in bytes |
| xfer_done | input | 1 | Chunk finished pulse |
| busy | output | 1 | Engine active |
| done | output | 1 | All passes complete |
| retry_error | output | 1 | Retry limit exceeded |
| timeout_error | output | 1 | Trigger wait timed out |

## Verification
The hardest case to reach is a timeout that expires while a write-back is still pending. The bench holds `wb_busy` high through the expiry and past it, checks that no error shows and the engine stays busy, and then releases `wb_busy`. Proving that a passing test clears the retry count is also hard. To do it, the bench changes the returned status word between single trigger pulses, giving the pattern fail, pass, fail, fail. With a limit of 1, only the last failure may raise the error.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RDREQ,
    ST_RDWAIT,
    ST_XREQ,
    ST_XWAIT,
    ST_HOLD
  } seq_state_t;

  typedef enum logic {
    CMP_EQ = 1'b0,
    CMP_NE = 1'b1
  } cmp_kind_t;
endpackage

// File: rtl/cds_trig_select.sv
module cds_trig_select #(
  parameter int LINES = 64,
  localparam int SEL_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] lines,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic             hit
);
  logic [LINES-1:0] onehot;

  for (genvar g = 0; g < LINES; g++) begin : g_dec
    assign onehot[g] = (sel == SEL_W'(g));
  end

  assign hit = en && |(lines & onehot);
endmodule

// File: rtl/cds_match.sv
module cds_match
  import cds_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] cmp,
  input  logic [DW-1:0] mask,
  input  cmp_kind_t     kind,
  output logic          pass
);
  logic differs;

  assign differs = |((cmp ^ rdata) & mask);
  assign pass    = (kind == CMP_NE) ? differs : !differs;
endmodule

// File: rtl/cds_timeout.sv
module cds_timeout #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [TW-1:0] reload,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= reload;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cds_chunk_track.sv
module cds_chunk_track #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             consume,
  input  logic [LEN_W-1:0] chunk_size,
  input  logic [LEN_W-1:0] total_size,
  input  logic [CNT_W-1:0] loop_cnt,
  output logic [LEN_W-1:0] cur_len,
  output logic             final_chunk
);
  logic [LEN_W-1:0] rem_q;
  logic [CNT_W-1:0] pass_q;
  logic             pass_end;

  assign cur_len     = (chunk_size == '0 || chunk_size > rem_q) ? rem_q : chunk_size;
  assign pass_end    = (rem_q == cur_len);
  assign final_chunk = pass_end && ((pass_q + CNT_W'(1)) == loop_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      pass_q <= '0;
    end else if (init) begin
      rem_q  <= total_size;
      pass_q <= '0;
    end else if (consume) begin
      if (pass_end) begin
        rem_q  <= total_size;
        pass_q <= pass_q + CNT_W'(1);
      end else begin
        rem_q <= rem_q - cur_len;
      end
    end
  end

  assert_len_fits_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> cur_len <= rem_q);
endmodule

// File: rtl/cond_dma_seq.sv
module cond_dma_seq
  import cds_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int LINES = 64,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16,
  parameter int TMO_W = 32,
  parameter int VER_W = 4,
  localparam int SEL_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode_en,
  input  logic [VER_W-1:0] desc_ver,
  input  logic             trig_en,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic             cond_type,
  input  logic [DW-1:0]    cmp_data,
  input  logic [DW-1:0]    cmp_mask,
  input  logic [AW-1:0]    status_addr,
  input  logic [LEN_W-1:0] chunk_size,
  input  logic [LEN_W-1:0] total_size,
  input  logic [CNT_W-1:0] loop_cnt,
  input  logic             retry_en,
  input  logic [CNT_W-1:0] retry_limit,
  input  logic             tmo_en,
  input  logic [TMO_W-1:0] tmo_reload,
  input  logic             start,
  input  logic             clr_status,
  input  logic [LINES-1:0] trig_vec,
  input  logic             wb_busy,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_rvalid,
  input  logic [DW-1:0]    rd_rdata,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  output logic [LEN_W-1:0] xfer_len,
  input  logic             xfer_done,
  output logic             busy,
  output logic             done,
  output logic             retry_error,
  output logic             timeout_error
);
  localparam logic [VER_W-1:0] COND_VER = VER_W'(1);

  seq_state_t       state_q;
  logic             plain_q;
  logic [CNT_W-1:0] fail_q;
  logic             done_q, rerr_q, terr_q;

  logic             ext_on;
  logic             trig_hit;
  logic             cmp_pass;
  logic             tmo_expired;
  logic             trk_init, trk_consume;
  logic [LEN_W-1:0] trk_len;
  logic             trk_final;
  logic             idle_start;

  assign ext_on     = ext_mode_en && (desc_ver == COND_VER) && trig_en;
  assign idle_start = (state_q == ST_IDLE) && start;

  cds_trig_select #(.LINES(LINES)) u_sel (
    .lines (trig_vec),
    .sel   (cond_sel),
    .en    (state_q == ST_WAIT),
    .hit   (trig_hit)
  );

  cds_match #(.DW(DW)) u_match (
    .rdata (rd_rdata),
    .cmp   (cmp_data),
    .mask  (cmp_mask),
    .kind  (cmp_kind_t'(cond_type)),
    .pass  (cmp_pass)
  );

  cds_timeout #(.TW(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (idle_start || trig_hit),
    .run     (state_q == ST_WAIT),
    .reload  (tmo_reload),
    .expired (tmo_expired)
  );

  assign trk_init    = idle_start;
  assign trk_consume = (state_q == ST_XWAIT) && xfer_done && !plain_q;

  cds_chunk_track #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init        (trk_init),
    .consume     (trk_consume),
    .chunk_size  (chunk_size),
    .total_size  (total_size),
    .loop_cnt    (loop_cnt),
    .cur_len     (trk_len),
    .final_chunk (trk_final)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      plain_q <= 1'b0;
      fail_q  <= '0;
      done_q  <= 1'b0;
      rerr_q  <= 1'b0;
      terr_q  <= 1'b0;
    end else begin
      if (clr_status) begin
        done_q <= 1'b0;
        rerr_q <= 1'b0;
        terr_q <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            done_q  <= 1'b0;
            rerr_q  <= 1'b0;
            terr_q  <= 1'b0;
            fail_q  <= '0;
            plain_q <= !ext_on;
            if (total_size == '0 || (ext_on && loop_cnt == '0)) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ext_on ? ST_WAIT : ST_XREQ;
            end
          end
        end
        ST_WAIT: begin
          if (trig_hit) begin
            state_q <= ST_RDREQ;
          end else if (tmo_en && tmo_expired) begin
            state_q <= ST_HOLD;
          end
        end
        ST_RDREQ: begin
          if (rd_ready) state_q <= ST_RDWAIT;
        end
        ST_RDWAIT: begin
          if (rd_rvalid) begin
            if (cmp_pass) begin
              fail_q  <= '0;
              state_q <= ST_XREQ;
            end else if (retry_en && fail_q == retry_limit) begin
              rerr_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              fail_q  <= fail_q + CNT_W'(1);
              state_q <= ST_WAIT;
            end
          end
        end
        ST_XREQ: begin
          if (xfer_ready) state_q <= ST_XWAIT;
        end
        ST_XWAIT: begin
          if (xfer_done) begin
            if (plain_q || trk_final) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_HOLD: begin
          if (!wb_busy) begin
            terr_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid      = (state_q == ST_RDREQ);
  assign rd_addr       = status_addr;
  assign xfer_valid    = (state_q == ST_XREQ);
  assign xfer_len      = plain_q ? total_size : trk_len;
  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign retry_error   = rerr_q;
  assign timeout_error = terr_q;

  assert_rd_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid);

  assert_xfer_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_len));

  assert_chunk_bound_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !plain_q && chunk_size != '0 |-> xfer_len <= chunk_size);

  assert_plain_no_read_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    busy && plain_q |-> !rd_valid);

  assert_status_excl_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, retry_error, timeout_error}));

  assert_tmo_after_wb_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_error) |-> !$past(wb_busy));
endmodule

// File: tb/test_cond_dma_seq.sv
`timescale 1ns/100ps
module test_cond_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode_en, trig_en, cond_type, retry_en, tmo_en, start, clr_status, wb_busy;
  logic [3:0]  desc_ver;
  logic [5:0]  cond_sel;
  logic [31:0] cmp_data, cmp_mask, status_addr, tmo_reload, rd_rdata;
  logic [15:0] chunk_size, total_size, loop_cnt, retry_limit, xfer_len;
  logic [63:0] trig_vec;
  logic        rd_valid, rd_ready, rd_rvalid, xfer_valid, xfer_ready, xfer_done;
  logic [31:0] rd_addr;
  logic        busy, done, retry_error, timeout_error;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  int xf_cnt = 0;
  int lens [0:15];
  logic [31:0] last_addr;
  logic [31:0] rd_model;
  bit rd_pend = 0;
  int done_dly = 0;

  always #2.5 clk = ~clk;

  cond_dma_seq i_cond_dma_seq (
    .clk(clk), .rst_n(rst_n), .ext_mode_en(ext_mode_en), .desc_ver(desc_ver),
    .trig_en(trig_en), .cond_sel(cond_sel), .cond_type(cond_type),
    .cmp_data(cmp_data), .cmp_mask(cmp_mask), .status_addr(status_addr),
    .chunk_size(chunk_size), .total_size(total_size), .loop_cnt(loop_cnt),
    .retry_en(retry_en), .retry_limit(retry_limit), .tmo_en(tmo_en),
    .tmo_reload(tmo_reload), .start(start), .clr_status(clr_status),
    .trig_vec(trig_vec), .wb_busy(wb_busy), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid),
    .rd_rdata(rd_rdata), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_len(xfer_len), .xfer_done(xfer_done), .busy(busy), .done(done),
    .retry_error(retry_error), .timeout_error(timeout_error)
  );

  // Read and chunk responders, driven on the falling edge
  always @(negedge clk) begin
    rd_rvalid = 1'b0;
    if (rd_pend) begin
      rd_rvalid = 1'b1;
      rd_rdata  = rd_model;
      rd_pend   = 0;
    end
    if (rd_valid && rd_ready) begin
      rd_pend   = 1;
      last_addr = rd_addr;
      rd_cnt++;
    end
    xfer_done = 1'b0;
    if (done_dly > 0) begin
      done_dly--;
      if (done_dly == 0) xfer_done = 1'b1;
    end
    if (xfer_valid && xfer_ready) begin
      if (xf_cnt < 16) lens[xf_cnt] = int'(xfer_len);
      xf_cnt++;
      done_dly = 2;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ext_mode_en = 1; desc_ver = 4'd1; trig_en = 1; cond_sel = 6'd3; cond_type = 0;
    cmp_data = 0; cmp_mask = 0; status_addr = 32'h4000_0010; chunk_size = 4;
    total_size = 8; loop_cnt = 1; retry_en = 0; retry_limit = 0; tmo_en = 0;
    tmo_reload = 0; start = 0; clr_status = 0; trig_vec = '0; wb_busy = 0;
    rd_ready = 1; xfer_ready = 1; rd_model = 0;
    rd_cnt = 0; xf_cnt = 0; rd_pend = 0; done_dly = 0;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic one_trig(int line);
    int old = rd_cnt;
    trig_vec[line] = 1'b1;
    while (rd_cnt == old) @(negedge clk);
    trig_vec[line] = 1'b0;
    waitc(8);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 busy", busy, 0);
    check("R11 status", {done, retry_error, timeout_error}, 0);
    check("R11 valids", {rd_valid, xfer_valid}, 0);
  endtask

  task automatic t_plain();
    do_reset();
    ext_mode_en = 0; total_size = 37; trig_vec = '1;
    pulse_start();
    waitc(15);
    check("R1 plain chunks", xf_cnt, 1);
    check("R1 plain len", lens[0], 37);
    check("R1 plain no read", rd_cnt, 0);
    check("R1 plain done", done, 1);
    do_reset();
    desc_ver = 4'd2; total_size = 21;
    pulse_start();
    waitc(15);
    check("R1 version2 len", lens[0], 21);
    check("R1 version2 reads", rd_cnt, 0);
  endtask

  task automatic t_full();
    do_reset();
    total_size = 10; chunk_size = 4; loop_cnt = 2; cond_sel = 6'd3;
    trig_vec[3] = 1'b1;
    pulse_start();
    waitc(120);
    check("R7 chunk count", xf_cnt, 6);
    check("R5 read count", rd_cnt, 6);
    check("R6 first len", lens[0], 4);
    check("R6 trimmed pass1", lens[2], 2);
    check("R6 trimmed pass2", lens[5], 2);
    check("R7 done", done, 1);
    check("R7 idle", busy, 0);
    waitc(20);
    check("R10 done held", done, 1);
    check("R7 no reads after done", rd_cnt, 6);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    check("R10 cleared", done, 0);
    do_reset();
    total_size = 6; chunk_size = 0;
    trig_vec[3] = 1'b1;
    pulse_start();
    waitc(30);
    check("R6 zero chunk len", lens[0], 6);
    check("R6 zero chunk count", xf_cnt, 1);
    do_reset();
    loop_cnt = 0;
    pulse_start();
    waitc(2);
    check("R7 zero loops done", done, 1);
    check("R7 zero loops idle", busy, 0);
  endtask

  task automatic t_select();
    do_reset();
    cond_sel = 6'd45; total_size = 4; chunk_size = 4;
    trig_vec = ~(64'd1 << 45);
    pulse_start();
    waitc(20);
    check("R2 other lines ignored", rd_cnt, 0);
    check("R2 still busy", busy, 1);
    trig_vec[45] = 1'b1;
    waitc(12);
    check("R3 read issued", rd_cnt, 1);
    check("R3 read address", int'(last_addr), int'(32'h4000_0010));
    check("R2 done", done, 1);
  endtask

  task automatic t_cmp();
    do_reset();
    cmp_data = 32'h0000_00A5; cmp_mask = 32'h0000_00FF; total_size = 16;
    pulse_start();
    rd_model = 32'h1234_56A4; one_trig(3);
    check("R4 eq mismatch no xfer", xf_cnt, 0);
    rd_model = 32'hFFFF_FFA5; one_trig(3);
    check("R4 eq masked match", xf_cnt, 1);
    do_reset();
    cmp_data = 32'h0000_00A5; cmp_mask = 32'h0000_00FF; total_size = 16; cond_type = 1;
    pulse_start();
    rd_model = 32'h7777_77A5; one_trig(3);
    check("R4 ne equal no xfer", xf_cnt, 0);
    rd_model = 32'h0000_00A4; one_trig(3);
    check("R4 ne differ xfer", xf_cnt, 1);
  endtask

  task automatic t_retry();
    do_reset();
    retry_en = 1; retry_limit = 2; cmp_mask = 32'hFFFF_FFFF; rd_model = 32'h1;
    trig_vec[3] = 1'b1;
    pulse_start();
    waitc(40);
    check("R8 reads before error", rd_cnt, 3);
    check("R8 retry error", retry_error, 1);
    check("R8 stopped", busy, 0);
    check("R8 no xfer", xf_cnt, 0);
    do_reset();
    retry_en = 1; retry_limit = 1; cmp_mask = 32'hFFFF_FFFF; total_size = 16;
    pulse_start();
    rd_model = 32'h1; one_trig(3);
    rd_model = 32'h0; one_trig(3);
    rd_model = 32'h1; one_trig(3);
    check("R8 count cleared by match", retry_error, 0);
    one_trig(3);
    check("R8 error after clear", retry_error, 1);
    do_reset();
    cmp_mask = 32'hFFFF_FFFF; rd_model = 32'h1;
    trig_vec[3] = 1'b1;
    pulse_start();
    waitc(60);
    check("R8 unlimited no error", retry_error, 0);
    check("R8 unlimited busy", busy, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    tmo_en = 1; tmo_reload = 10;
    pulse_start();
    waitc(7);
    check("R9 not yet", timeout_error, 0);
    waitc(13);
    check("R9 expired", timeout_error, 1);
    check("R9 stopped", busy, 0);
    do_reset();
    tmo_en = 1; tmo_reload = 12; cmp_mask = 32'hFFFF_FFFF; rd_model = 32'h1;
    pulse_start();
    for (int i = 0; i < 6; i++) one_trig(3);
    check("R9 reload on trigger", timeout_error, 0);
    check("R9 reload busy", busy, 1);
    do_reset();
    tmo_en = 1; tmo_reload = 5; wb_busy = 1;
    pulse_start();
    waitc(30);
    check("R9 held by write-back", timeout_error, 0);
    check("R9 busy during write-back", busy, 1);
    wb_busy = 0;
    waitc(3);
    check("R9 error after write-back", timeout_error, 1);
  endtask

  task automatic t_backpressure();
    do_reset();
    xfer_ready = 0; total_size = 8;
    pulse_start();
    trig_vec[3] = 1'b1;
    waitc(8);
    trig_vec[3] = 1'b0;
    check("R5 valid waiting", xfer_valid, 1);
    check("R5 len waiting", int'(xfer_len), 4);
    waitc(5);
    check("R5 valid held", xfer_valid, 1);
    check("R5 no accept", xf_cnt, 0);
    check("R5 one read only", rd_cnt, 1);
    xfer_ready = 1;
    waitc(8);
    check("R5 accepted", xf_cnt, 1);
    check("R5 back to wait", busy, 1);
  endtask

  initial begin
    #(5ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_full();
    t_select();
    t_cmp();
    t_retry();
    t_timeout();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule